// File: doc/BRIEF.md
# Expansion ROM Window Decoder

This block owns the expansion ROM base register of a PCI-style configuration header and decides, cycle by cycle, whether a memory transaction on the bus falls inside the device's ROM window. The host sizes the window by writing all ones to the register and reading it back. It then programs a base on any 1 MB boundary and sets the ROM enable bit. When that bit and the memory-space enable from the command register are both set, every valid memory command whose address lands in the 1 MB window produces a registered claim one clock later. The claim drives the device-select response.

The same register slice also serves two neighbouring header fields. One is a read-only capability pointer. The other is an interrupt line byte that software reads and writes and that the device never acts on. Configuration accesses use a dword index with per-byte enables. Read data is combinational while the read strobe is high.

The address-phase input is a one-way stream qualified by `bus_valid`. There is no ready signal: the decoder accepts one address phase every clock and never applies back-pressure, and each accepted phase yields exactly one claim decision on the following clock.

Top module: `rom_window_decoder`

## Requirements
- R1: The ROM register sits at dword index 0Ch (byte offset 30h). It reads back as {base[11:0] in bits 31:20, zeros in 19:1, enable in bit 0}. A full write stores bits 31:20 as the base and bit 0 as the enable.
- R2: Bits 19:1 of the ROM register always read zero and ignore writes, so a write of FFFFFFFFh reads back as FFF00001h.
- R3: Configuration writes honour the byte enables. Byte enable 3 gates base bits 31:24, byte enable 2 gates base bits 23:20, and byte enable 0 gates the ROM enable (index 0Ch) or the interrupt line (index 0Fh). Bytes that are not enabled keep their value.
- R4: A claim needs all of the following: `bus_valid` high, the ROM enable set, `mem_space_en` set, and a memory command. The memory command codes are 6h, 7h, Ch, Eh and Fh. I/O codes (2h, 3h), configuration codes (Ah, Bh) and all other codes never claim.
- R5: An address hits when its bits 31:20 equal the base. Equivalently, address bits 31:2 lie between the base and base + 1 MB − 4, inclusive. The address just below the window and the address exactly 1 MB above the base do not hit.
- R6: `claim` is registered. It reflects the address phase presented on the previous clock and is low in any cycle that follows a cycle with `bus_valid` low.
- R7: Hard reset (`hrst_n` low) clears the base, the ROM enable, the interrupt line and `claim`.
- R8: Pulses on `soft_rst` or `stop_req` leave the base, the ROM enable and the interrupt line unchanged.
- R9: Index 0Dh (byte offset 34h) reads 00000040h, and writes to it have no effect.
- R10: Index 0Fh (byte offset 3Ch) holds an 8-bit interrupt line in bits 7:0, with bits 31:8 reading zero. Its value never affects `claim`.
- R11: Reads of any other index return zero, and writes to them change no register. `cfg_rdata` is zero while `cfg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset request; does not touch this block's registers |
| stop_req | input | 1 | Stop request; does not touch this block's registers |
| mem_space_en | input | 1 | Memory-space enable from the command register |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| bus_valid | input | 1 | Address phase valid |
| bus_cmd | input | 4 | Bus command code |
| bus_addr_dw | input | 30 | Address bits 31:2 of the address phase |
| claim | output | 1 | Registered window claim (device-select request) |

## Verification
The bench probes addresses one dword below the window, at its base, at its last dword and exactly 1 MB above the base. A decoder with an off-by-one or the wrong compare width would claim outside the window or drop its last dword. It sweeps every command code with both enables on and off. A design that treated I/O or configuration codes as memory, or that ignored one of the enables, would claim where it must stay silent. Partial byte-enable writes and soft reset or stop pulses are followed by readback. An implementation that writes whole dwords, or that ties the ROM fields to soft reset, returns a stale or cleared register. All-ones sizing writes confirm that the size bits stay zero.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

  typedef logic [3:0] bus_cmd_t;

  // Memory command codes that can reach the ROM window
  localparam bus_cmd_t CMD_MEM_RD      = 4'h6;
  localparam bus_cmd_t CMD_MEM_WR      = 4'h7;
  localparam bus_cmd_t CMD_MEM_RD_MULT = 4'hC;
  localparam bus_cmd_t CMD_MEM_RD_LINE = 4'hE;
  localparam bus_cmd_t CMD_MEM_WR_INV  = 4'hF;

  // Dword indices of the header fields served here
  localparam logic [5:0] IDX_ROM_BAR  = 6'h0C;
  localparam logic [5:0] IDX_CAP_PTR  = 6'h0D;
  localparam logic [5:0] IDX_INT_LINE = 6'h0F;

  function automatic logic is_mem_cmd(input bus_cmd_t c);
    case (c)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RD_MULT,
      CMD_MEM_RD_LINE, CMD_MEM_WR_INV: is_mem_cmd = 1'b1;
      default:                         is_mem_cmd = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rwd_cfg_regs.sv
module rwd_cfg_regs
  import rwd_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_LOG2 = 20,
  parameter logic [7:0]  CAP_VAL  = 8'h40
) (
  input  logic                       clk,
  input  logic                       hrst_n,
  input  logic                       soft_rst,
  input  logic                       stop_req,
  input  logic                       cfg_wr,
  input  logic                       cfg_rd,
  input  logic [5:0]                 cfg_idx,
  input  logic [3:0]                 cfg_be,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  output logic [ADDR_W-WIN_LOG2-1:0] rom_base,
  output logic                       rom_en
);

  localparam int BASE_W = ADDR_W - WIN_LOG2;

  logic [BASE_W-1:0] base_q;
  logic              en_q;
  logic [7:0]        intl_q;
  logic [BASE_W-1:0] base_bmask;

  // Expand byte enables to a per-bit mask over the base field
  always_comb begin
    for (int b = 0; b < BASE_W; b++) begin
      base_bmask[b] = cfg_be[(b + WIN_LOG2) / 8];
    end
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      intl_q <= 8'h00;
    end else if (cfg_wr) begin
      case (cfg_idx)
        IDX_ROM_BAR: begin
          base_q <= (base_q & ~base_bmask) |
                    (cfg_wdata[ADDR_W-1:WIN_LOG2] & base_bmask);
          if (cfg_be[0]) en_q <= cfg_wdata[0];
        end
        IDX_INT_LINE: begin
          if (cfg_be[0]) intl_q <= cfg_wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      case (cfg_idx)
        IDX_ROM_BAR:  cfg_rdata = {base_q, {(WIN_LOG2-1){1'b0}}, en_q};
        IDX_CAP_PTR:  cfg_rdata = {24'h0, CAP_VAL};
        IDX_INT_LINE: cfg_rdata = {24'h0, intl_q};
        default:      cfg_rdata = '0;
      endcase
    end
  end

  assign rom_base = base_q;
  assign rom_en   = en_q;

  // Inputs or bits that no register consumes
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata, cfg_be, soft_rst, stop_req};

  // R2: size bits read as zero whenever the ROM register is read
  p_size_zero_r2: assert property (@(posedge clk) disable iff (!hrst_n)
    (cfg_rd && cfg_idx == IDX_ROM_BAR) |-> (cfg_rdata[WIN_LOG2-1:1] == '0));

  // R8: soft reset and stop alone leave the stored fields untouched
  p_soft_keep_r8: assert property (@(posedge clk) disable iff (!hrst_n)
    ((soft_rst || stop_req) && !cfg_wr) |=>
      ($stable(base_q) && $stable(en_q) && $stable(intl_q)));

  // R9: capability pointer reads its constant
  p_cap_const_r9: assert property (@(posedge clk) disable iff (!hrst_n)
    (cfg_rd && cfg_idx == IDX_CAP_PTR) |-> (cfg_rdata == {24'h0, CAP_VAL}));

  // R11: idle read port returns zero
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!hrst_n)
    !cfg_rd |-> (cfg_rdata == '0));

  // R11: writes elsewhere change nothing
  p_wr_other_r11: assert property (@(posedge clk) disable iff (!hrst_n)
    (cfg_wr && cfg_idx != IDX_ROM_BAR && cfg_idx != IDX_INT_LINE) |=>
      ($stable(base_q) && $stable(en_q) && $stable(intl_q)));

endmodule

// File: rtl/rwd_window_match.sv
module rwd_window_match
  import rwd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 20
) (
  input  logic                       clk,
  input  logic                       hrst_n,
  input  logic                       bus_valid,
  input  bus_cmd_t                   bus_cmd,
  input  logic [ADDR_W-1:2]          bus_addr_dw,
  input  logic [ADDR_W-WIN_LOG2-1:0] rom_base,
  input  logic                       rom_en,
  input  logic                       mem_space_en,
  output logic                       claim
);

  logic addr_hit;
  logic cmd_mem;
  logic enabled;
  logic claim_q;

  assign addr_hit = (bus_addr_dw[ADDR_W-1:WIN_LOG2] == rom_base);
  assign cmd_mem  = is_mem_cmd(bus_cmd);
  assign enabled  = rom_en && mem_space_en;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) claim_q <= 1'b0;
    else         claim_q <= bus_valid && cmd_mem && enabled && addr_hit;
  end

  assign claim = claim_q;

  // Offset bits inside the window do not take part in the decision
  logic unused_addr_lo;
  assign unused_addr_lo = ^bus_addr_dw[WIN_LOG2-1:2];

  // R4: non-memory commands never claim
  p_nonmem_quiet_r4: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_valid && !is_mem_cmd(bus_cmd)) |=> !claim);

  // R4: both enables are needed
  p_need_enables_r4: assert property (@(posedge clk) disable iff (!hrst_n)
    !(rom_en && mem_space_en) |=> !claim);

  // R5: an enabled memory hit is claimed on the next clock
  p_hit_claims_r5: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_valid && is_mem_cmd(bus_cmd) && rom_en && mem_space_en &&
     bus_addr_dw[ADDR_W-1:WIN_LOG2] == rom_base) |=> claim);

  // R5: a miss is never claimed
  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_addr_dw[ADDR_W-1:WIN_LOG2] != rom_base) |=> !claim);

endmodule

// File: rtl/rom_window_decoder.sv
module rom_window_decoder
  import rwd_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter int         WIN_LOG2 = 20,
  parameter logic [7:0] CAP_VAL  = 8'h40
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              soft_rst,
  input  logic              stop_req,
  input  logic              mem_space_en,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [5:0]        cfg_idx,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              bus_valid,
  input  logic [3:0]        bus_cmd,
  input  logic [ADDR_W-1:2] bus_addr_dw,
  output logic              claim
);

  localparam int BASE_W = ADDR_W - WIN_LOG2;

  logic [BASE_W-1:0] rom_base;
  logic              rom_en;

  rwd_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .WIN_LOG2(WIN_LOG2),
    .CAP_VAL (CAP_VAL)
  ) u_cfg (
    .clk      (clk),
    .hrst_n   (hrst_n),
    .soft_rst (soft_rst),
    .stop_req (stop_req),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_idx  (cfg_idx),
    .cfg_be   (cfg_be),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .rom_base (rom_base),
    .rom_en   (rom_en)
  );

  rwd_window_match #(
    .ADDR_W  (ADDR_W),
    .WIN_LOG2(WIN_LOG2)
  ) u_match (
    .clk         (clk),
    .hrst_n      (hrst_n),
    .bus_valid   (bus_valid),
    .bus_cmd     (bus_cmd),
    .bus_addr_dw (bus_addr_dw),
    .rom_base    (rom_base),
    .rom_en      (rom_en),
    .mem_space_en(mem_space_en),
    .claim       (claim)
  );

  // R6: a claim always follows a valid address phase
  p_claim_after_valid_r6: assert property (@(posedge clk) disable iff (!hrst_n)
    claim |-> $past(bus_valid));

endmodule

// File: tb/rom_window_decoder_tb_top.sv
module rom_window_decoder_tb_top;

  logic        clk = 1'b0;
  logic        hrst_n = 1'b0;
  logic        soft_rst = 1'b0, stop_req = 1'b0, mem_space_en = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_cmd = '0;
  logic [31:2] bus_addr_dw = '0;
  logic        claim;

  int vectors = 0;
  int fails = 0;

  // Bench model of the register state
  logic [11:0] m_base = '0;
  logic        m_en = 1'b0;
  logic [7:0]  m_il = '0;

  always #4 clk = ~clk;

  rom_window_decoder dut_i (
    .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .stop_req(stop_req),
    .mem_space_en(mem_space_en), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr_dw(bus_addr_dw), .claim(claim)
  );

  function automatic logic [31:0] exp_read(input logic [5:0] idx);
    case (idx)
      6'h0C:   return {m_base, 19'h0, m_en};
      6'h0D:   return 32'h0000_0040;
      6'h0F:   return {24'h0, m_il};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_claim(input logic [3:0] cmd,
                                     input logic [31:0] addr,
                                     input logic me);
    logic memc;
    memc = (cmd == 4'h6) || (cmd == 4'h7) || (cmd == 4'hC) ||
           (cmd == 4'hE) || (cmd == 4'hF);
    return memc && me && m_en && (addr[31:20] == m_base);
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be,
                           input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (idx == 6'h0C) begin
      if (be[3]) m_base[11:4] = d[31:24];
      if (be[2]) m_base[3:0]  = d[23:20];
      if (be[0]) m_en         = d[0];
    end else if (idx == 6'h0F) begin
      if (be[0]) m_il = d[7:0];
    end
  endtask

  task automatic cfg_read(input logic [5:0] idx, input string req);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    #1;
    chk(req, cfg_rdata, exp_read(idx));
    cfg_rd = 1'b0;
    #1;
    chk("R11 idle rdata", cfg_rdata, 32'h0);
  endtask

  task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr,
                           input string req);
    logic e;
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = cmd; bus_addr_dw = addr[31:2];
    e = exp_claim(cmd, addr, mem_space_en);
    @(negedge clk);
    bus_valid = 1'b0;
    chk(req, {31'h0, claim}, {31'h0, e});
    @(negedge clk);
    chk("R6 claim drops after idle", {31'h0, claim}, 32'h0);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    hrst_n = 1'b0;
    m_base = '0; m_en = 1'b0; m_il = '0;
    #2;
    chk("R7 claim in reset", {31'h0, claim}, 32'h0);
    @(negedge clk);
    hrst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] wb;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    hrst_n = 1'b1;

    // R7 reset state
    cfg_read(6'h0C, "R7 rom reg after reset");
    cfg_read(6'h0F, "R7 int line after reset");
    chk("R7 claim after reset", {31'h0, claim}, 32'h0);

    // R2 sizing
    cfg_write(6'h0C, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h0C, "R2 sizing readback");
    chk("R2 sizing value", exp_read(6'h0C), 32'hFFF0_0001);

    // R1 program base 0x123 with enable
    cfg_write(6'h0C, 4'hF, 32'h1234_5671);
    cfg_read(6'h0C, "R1 base and enable");
    mem_space_en = 1'b1;
    wb = {m_base, 20'h0};
    bus_cycle(4'h6, wb,              "R5 window base");
    bus_cycle(4'h6, wb + 32'hFFFFC,  "R5 window last dword");
    bus_cycle(4'h7, wb - 32'h4,      "R5 just below window");
    bus_cycle(4'h6, wb + 32'h100000, "R5 one window above");
    bus_cycle(4'hC, wb + 32'h3, "R5 byte lanes ignored");

    // R6 timing: claim not yet visible before the capturing edge
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = 4'hE; bus_addr_dw = wb[31:2];
    #1 chk("R6 no early claim", {31'h0, claim}, 32'h0);
    @(negedge clk);
    chk("R6 claim one clock later", {31'h0, claim}, 32'h1);
    bus_valid = 1'b0;
    @(negedge clk);
    chk("R6 claim drops", {31'h0, claim}, 32'h0);

    // R4 every command code, enables on
    for (int c = 0; c < 16; c++) bus_cycle(c[3:0], wb + 32'h40, "R4 command sweep");
    // R4 memory enable off
    mem_space_en = 1'b0;
    bus_cycle(4'h6, wb, "R4 mem space disabled");
    mem_space_en = 1'b1;
    // R4 ROM enable off
    cfg_write(6'h0C, 4'h1, 32'h0);
    bus_cycle(4'h6, wb, "R4 rom enable clear");
    cfg_read(6'h0C, "R3 enable-only write");

    // R3 partial writes
    cfg_write(6'h0C, 4'h8, 32'hAB00_0001);
    cfg_read(6'h0C, "R3 byte3 only");
    cfg_write(6'h0C, 4'h4, 32'h00F0_0000);
    cfg_read(6'h0C, "R3 byte2 only");
    cfg_write(6'h0C, 4'h2, 32'hFFFF_FFFF);
    cfg_read(6'h0C, "R3 byte1 ignored");

    // R9 capability pointer
    cfg_write(6'h0D, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h0D, "R9 cap pointer");

    // R10 interrupt line, no effect on claim
    cfg_write(6'h0C, 4'h1, 32'h1);
    cfg_write(6'h0F, 4'hF, 32'hDEAD_BE5A);
    cfg_read(6'h0F, "R10 int line");
    wb = {m_base, 20'h0};
    bus_cycle(4'h6, wb + 32'h800, "R10 claim unaffected by int line");

    // R11 other offsets
    cfg_write(6'h0E, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h0E, "R11 unimplemented index");
    cfg_read(6'h00, "R11 outside range");
    cfg_read(6'h0C, "R11 rom reg untouched");

    // R8 soft reset and stop
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    cfg_read(6'h0C, "R8 rom reg kept");
    cfg_read(6'h0F, "R8 int line kept");
    bus_cycle(4'h6, wb, "R8 claim still works");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) begin
        logic [5:0] ri;
        ri = 6'h0C + 6'($urandom_range(0, 3));
        cfg_write(ri, 4'($urandom), $urandom);
      end else if (op < 4) begin
        cfg_read(6'h0C + 6'($urandom_range(0, 3)), "R1 random read");
      end else begin
        logic [31:0] a;
        logic [3:0]  cm;
        case ($urandom_range(0, 3))
          0: a = {m_base, 20'($urandom)};
          1: a = {m_base, 20'h0} - 32'h4;
          2: a = {m_base, 20'h0} + 32'h100000;
          default: a = $urandom;
        endcase
        cm = ($urandom_range(0, 1) == 1) ? 4'h6 : 4'($urandom);
        mem_space_en = ($urandom_range(0, 7) != 0);
        bus_cycle(cm, a, "R5 random cycle");
      end
      if (i == 300) begin
        hard_reset();
        cfg_read(6'h0C, "R7 rom reg after mid reset");
        cfg_read(6'h0F, "R7 int line after mid reset");
        cfg_write(6'h0C, 4'hF, 32'h8000_0001);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule